// File: doc/BRIEF.md
# Six-Point Prime-Factor DFT Pipeline

This block computes a complete 6-point discrete Fourier transform on a set of six complex fixed-point samples in every clock cycle. Bin k is the sum over n of x(n)·W^(nk), with W = exp(-j2π/6). Lengths 2 and 3 are coprime, so the block uses a prime-factor split. Each input index n is addressed by its residues modulo 2 and modulo 3. Three 2-point butterflies run first. Two 3-point butterflies then work on their results directly, with no rotation factor applied between the two stages. A Chinese-remainder map places each 3-point result in its natural bin slot, so no reordering is needed after the block.

Each 3-point butterfly uses only two real constant multiplications, by sin(60°) held as a 16-bit coefficient with 15 fractional bits. The factor of one half is an arithmetic right shift. The datapath has three register stages: the 2-point add, the 3-point shift/multiply, and the 3-point combine. A new set can be presented on every cycle. The output is three bits wider than the input, so no input pattern can overflow.

Top module: `dft6_core`

## Requirements
- R1: When valid_out is high, bin 0 (out slice 0) equals exactly the sum of the six input samples captured three cycles earlier, for both the real and imaginary parts.
- R2: When valid_out is high, bin 3 (out slice 3) equals exactly x0 − x1 + x2 − x3 + x4 − x5 of the captured set.
- R3: Bins 1, 2, 4 and 5 match the transform definition with W = exp(−j2π/6) to within 2 LSB in each of the real and imaginary parts.
- R4: Outputs are in natural order. Output slice k carries bin k, and input slice n carries sample x(n). A single impulse at any input position n produces v·W^(nk) at slice k.
- R5: valid_out equals valid_in delayed by exactly 3 clock cycles. Sets presented on consecutive cycles, or with gaps, each produce exactly one result.
- R6: While valid_out is low, out_re and out_im hold their previous values.
- R7: When all imaginary inputs of a set are zero, the result is exactly conjugate-symmetric: bin 5 is the conjugate of bin 1, and bin 4 is the conjugate of bin 2.
- R8: Full-scale inputs (every part at +2^(DW−1)−1 or −2^(DW−1), including alternating signs) give exact DC and alternating-sum bins, with no wrap. Outputs are two's complement, DW+3 bits wide.
- R9: valid_out is low while rst_n is low, and stays low until the first accepted set has traversed the pipeline.
- R10: An impulse of value v at position 0 gives v exactly in every bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_in | input | 1 | Marks the current input set as valid |
| in_re | input | 6×DW | Real parts of x(0..5); slice n is x(n), two's complement |
| in_im | input | 6×DW | Imaginary parts of x(0..5) |
| valid_out | output | 1 | Marks the result set; valid_in delayed by 3 cycles |
| out_re | output | 6×(DW+3) | Real parts of bins 0..5; slice k is bin k |
| out_im | output | 6×(DW+3) | Imaginary parts of bins 0..5 |

## Verification
In any one cycle, the block can be accepting a new set while older sets sit in the multiply stage and the combine stage. The hold behaviour of the output registers can also coincide with a gap in the input stream. Back-to-back random streams keep all three stages busy at once. Gapped streams with random spacing make a result emerge in the same cycle that a gap enters the pipeline. A queue-based reference model in the bench timestamps every accepted set and expects its transform exactly three cycles later. It expects held outputs and a low valid in every other cycle, so a set that is lost, duplicated, shifted in time or mixed with a neighbouring set fails the comparison.

// File: rtl/dft6_pkg.sv
`timescale 1ns/1ps
package dft6_pkg;
  localparam int unsigned NPT       = 6;
  localparam int unsigned RAD_A     = 2;
  localparam int unsigned RAD_B     = 3;
  localparam int unsigned PIPE_LAT  = 3;
  localparam int unsigned COEF_W    = 16;
  localparam int unsigned COEF_FRAC = 15;
  // sin(60 deg) = 0.8660254 scaled by 2^15 and rounded
  localparam logic signed [COEF_W-1:0] SIN60_Q15 = 16'sd28378;

  // residue pair (i2, i3) -> input sample position, Good-Thomas input map
  function automatic int unsigned pfa_in_idx(input int unsigned i2, input int unsigned i3);
    return (3 * i2 + 2 * i3) % NPT;
  endfunction

  // residue pair (k2, k3) -> natural bin index, CRT output map
  function automatic int unsigned crt_out_idx(input int unsigned k2, input int unsigned k3);
    return (3 * k2 + 4 * k3) % NPT;
  endfunction
endpackage

// File: rtl/dft6_rst_sync.sv
`timescale 1ns/1ps
module dft6_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/dft6_bfly2.sv
`timescale 1ns/1ps
module dft6_bfly2 #(
  parameter int IW = 12
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IW-1:0]     a_re,
  input  logic [IW-1:0]     a_im,
  input  logic [IW-1:0]     b_re,
  input  logic [IW-1:0]     b_im,
  output logic [IW:0]       sum_re,
  output logic [IW:0]       sum_im,
  output logic [IW:0]       dif_re,
  output logic [IW:0]       dif_im
);
  logic [IW:0] sum_re_d, sum_im_d, dif_re_d, dif_im_d;

  always_comb begin
    sum_re_d = {a_re[IW-1], a_re} + {b_re[IW-1], b_re};
    sum_im_d = {a_im[IW-1], a_im} + {b_im[IW-1], b_im};
    dif_re_d = {a_re[IW-1], a_re} - {b_re[IW-1], b_re};
    dif_im_d = {a_im[IW-1], a_im} - {b_im[IW-1], b_im};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_re <= sum_re_d;
      sum_im <= sum_im_d;
      dif_re <= dif_re_d;
      dif_im <= dif_im_d;
    end
  end
endmodule

// File: rtl/dft6_bfly3.sv
`timescale 1ns/1ps
module dft6_bfly3
  import dft6_pkg::*;
#(
  parameter int IW = 13
) (
  input  logic            clk,
  input  logic            en_mul,
  input  logic            en_add,
  input  logic [IW-1:0]   a_re,
  input  logic [IW-1:0]   a_im,
  input  logic [IW-1:0]   b_re,
  input  logic [IW-1:0]   b_im,
  input  logic [IW-1:0]   c_re,
  input  logic [IW-1:0]   c_im,
  output logic [IW+1:0]   y0_re,
  output logic [IW+1:0]   y0_im,
  output logic [IW+1:0]   y1_re,
  output logic [IW+1:0]   y1_im,
  output logic [IW+1:0]   y2_re,
  output logic [IW+1:0]   y2_im
);
  localparam int SW = IW + 1;
  localparam int YW = IW + 2;
  localparam int PW = SW + COEF_W - 1;
  localparam logic signed [PW-1:0] RND_HALF = PW'(1) << (COEF_FRAC - 1);

  // multiply stage, next-state
  logic [SW-1:0] s_re, s_im, t_re, t_im;
  logic signed [SW-1:0] d_re, d_im;
  logic [IW-1:0] sh_re, sh_im;
  logic signed [PW-1:0] prod_re, prod_im, rnd_re, rnd_im;
  logic [SW-1:0] pd_re_d, pd_im_d;

  always_comb begin
    s_re  = {b_re[IW-1], b_re} + {c_re[IW-1], c_re};
    s_im  = {b_im[IW-1], b_im} + {c_im[IW-1], c_im};
    d_re  = {b_re[IW-1], b_re} - {c_re[IW-1], c_re};
    d_im  = {b_im[IW-1], b_im} - {c_im[IW-1], c_im};
    sh_re = s_re[SW-1:1];
    sh_im = s_im[SW-1:1];
    t_re  = {a_re[IW-1], a_re} - {sh_re[IW-1], sh_re};
    t_im  = {a_im[IW-1], a_im} - {sh_im[IW-1], sh_im};
    prod_re = d_re * SIN60_Q15;
    prod_im = d_im * SIN60_Q15;
    rnd_re  = prod_re + RND_HALF;
    rnd_im  = prod_im + RND_HALF;
    pd_re_d = rnd_re[COEF_FRAC +: SW];
    pd_im_d = rnd_im[COEF_FRAC +: SW];
  end

  // multiply stage, registers
  logic [IW-1:0] a_re_q, a_im_q;
  logic [SW-1:0] s_re_q, s_im_q, t_re_q, t_im_q, pd_re_q, pd_im_q;

  always_ff @(posedge clk) begin
    if (en_mul) begin
      a_re_q  <= a_re;
      a_im_q  <= a_im;
      s_re_q  <= s_re;
      s_im_q  <= s_im;
      t_re_q  <= t_re;
      t_im_q  <= t_im;
      pd_re_q <= pd_re_d;
      pd_im_q <= pd_im_d;
    end
  end

  // combine stage, next-state
  logic [YW-1:0] y0_re_d, y0_im_d, y1_re_d, y1_im_d, y2_re_d, y2_im_d;
  logic [YW-1:0] tx_re, tx_im, px_re, px_im;

  always_comb begin
    tx_re = {t_re_q[SW-1], t_re_q};
    tx_im = {t_im_q[SW-1], t_im_q};
    px_re = {pd_re_q[SW-1], pd_re_q};
    px_im = {pd_im_q[SW-1], pd_im_q};
    y0_re_d = {{2{a_re_q[IW-1]}}, a_re_q} + {s_re_q[SW-1], s_re_q};
    y0_im_d = {{2{a_im_q[IW-1]}}, a_im_q} + {s_im_q[SW-1], s_im_q};
    // W3 = -1/2 - j*sin60 ; -j*sin60*d = (pd_im) - j(pd_re)
    y1_re_d = tx_re + px_im;
    y1_im_d = tx_im - px_re;
    y2_re_d = tx_re - px_im;
    y2_im_d = tx_im + px_re;
  end

  // combine stage, registers
  always_ff @(posedge clk) begin
    if (en_add) begin
      y0_re <= y0_re_d;
      y0_im <= y0_im_d;
      y1_re <= y1_re_d;
      y1_im <= y1_im_d;
      y2_re <= y2_re_d;
      y2_im <= y2_im_d;
    end
  end
endmodule

// File: rtl/dft6_core.sv
`timescale 1ns/1ps
module dft6_core
  import dft6_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_in,
  input  logic [NPT-1:0][DW-1:0]      in_re,
  input  logic [NPT-1:0][DW-1:0]      in_im,
  output logic                        valid_out,
  output logic [NPT-1:0][DW+2:0]      out_re,
  output logic [NPT-1:0][DW+2:0]      out_im
);
  localparam int W1 = DW + 1;
  localparam int OW = DW + 3;

  logic srst_n;

  dft6_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // valid pipeline with explicit next-state
  logic [PIPE_LAT-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = {vld_q[PIPE_LAT-2:0], valid_in};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  assign valid_out = vld_q[PIPE_LAT-1];

  // radix-2 stage: one butterfly per mod-3 residue
  logic [W1-1:0] r2_re [RAD_A][RAD_B];
  logic [W1-1:0] r2_im [RAD_A][RAD_B];

  for (genvar g3 = 0; g3 < RAD_B; g3++) begin : g_r2
    localparam int unsigned IA = pfa_in_idx(0, g3);
    localparam int unsigned IB = pfa_in_idx(1, g3);
    dft6_bfly2 #(.IW(DW)) u_b2 (
      .clk    (clk),
      .en     (valid_in),
      .a_re   (in_re[IA]),
      .a_im   (in_im[IA]),
      .b_re   (in_re[IB]),
      .b_im   (in_im[IB]),
      .sum_re (r2_re[0][g3]),
      .sum_im (r2_im[0][g3]),
      .dif_re (r2_re[1][g3]),
      .dif_im (r2_im[1][g3])
    );
  end

  // radix-3 stage: one butterfly per mod-2 residue, outputs placed by CRT
  for (genvar g2 = 0; g2 < RAD_A; g2++) begin : g_r3
    localparam int unsigned K0 = crt_out_idx(g2, 0);
    localparam int unsigned K1 = crt_out_idx(g2, 1);
    localparam int unsigned K2 = crt_out_idx(g2, 2);
    logic [OW-1:0] y0r, y0i, y1r, y1i, y2r, y2i;

    dft6_bfly3 #(.IW(W1)) u_b3 (
      .clk    (clk),
      .en_mul (vld_q[0]),
      .en_add (vld_q[1]),
      .a_re   (r2_re[g2][0]),
      .a_im   (r2_im[g2][0]),
      .b_re   (r2_re[g2][1]),
      .b_im   (r2_im[g2][1]),
      .c_re   (r2_re[g2][2]),
      .c_im   (r2_im[g2][2]),
      .y0_re  (y0r),
      .y0_im  (y0i),
      .y1_re  (y1r),
      .y1_im  (y1i),
      .y2_re  (y2r),
      .y2_im  (y2i)
    );

    assign out_re[K0] = y0r;
    assign out_im[K0] = y0i;
    assign out_re[K1] = y1r;
    assign out_im[K1] = y1i;
    assign out_re[K2] = y2r;
    assign out_im[K2] = y2i;
  end
endmodule

// File: rtl/dft6_core_chk.sv
`timescale 1ns/1ps
module dft6_core_chk
  import dft6_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_in,
  input  logic [NPT-1:0][DW-1:0] in_re,
  input  logic [NPT-1:0][DW-1:0] in_im,
  input  logic                   valid_out,
  input  logic [NPT-1:0][DW+2:0] out_re,
  input  logic [NPT-1:0][DW+2:0] out_im
);
  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  int dc_re, dc_im, alt_re, alt_im;
  logic real_in;

  always_comb begin
    dc_re = 0; dc_im = 0; alt_re = 0; alt_im = 0;
    for (int n = 0; n < NPT; n++) begin
      dc_re += int'($signed(in_re[n]));
      dc_im += int'($signed(in_im[n]));
      if (n % 2 == 0) begin
        alt_re += int'($signed(in_re[n]));
        alt_im += int'($signed(in_im[n]));
      end else begin
        alt_re -= int'($signed(in_re[n]));
        alt_im -= int'($signed(in_im[n]));
      end
    end
    real_in = (in_im == '0);
  end

  // R5
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7) |-> (valid_out == $past(valid_in, 3)));

  // R9
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 3'd3) |-> !valid_out);

  // R1
  dc_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (int'($signed(out_re[0])) == $past(dc_re, 3)) &&
                  (int'($signed(out_im[0])) == $past(dc_im, 3)));

  // R2
  alt_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (int'($signed(out_re[3])) == $past(alt_re, 3)) &&
                  (int'($signed(out_im[3])) == $past(alt_im, 3)));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age != 3'd0) && !valid_out) |-> ($stable(out_re) && $stable(out_im)));

  // R7
  conj_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && $past(real_in, 3)) |->
      (out_re[1] == out_re[5]) && (out_re[2] == out_re[4]) &&
      (int'($signed(out_im[1])) == -int'($signed(out_im[5]))) &&
      (int'($signed(out_im[2])) == -int'($signed(out_im[4]))));
endmodule

bind dft6_core dft6_core_chk #(.DW(DW)) u_dft6_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .in_re     (in_re),
  .in_im     (in_im),
  .valid_out (valid_out),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/test_dft6_core.sv
`timescale 1ns/1ps
module test_dft6_core;
  localparam int DW  = 12;
  localparam int OW  = DW + 3;
  localparam int LAT = 3;
  localparam int TOL = 2;
  localparam int PMAX = (1 << (DW - 1)) - 1;
  localparam int PMIN = -(1 << (DW - 1));
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n;
  logic valid_in;
  logic [5:0][DW-1:0] in_re, in_im;
  logic valid_out;
  logic [5:0][OW-1:0] out_re, out_im;

  always #2.5 clk = ~clk;

  dft6_core #(.DW(DW)) i_dft6_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .in_re     (in_re),
    .in_im     (in_im),
    .valid_out (valid_out),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  typedef struct {
    int due;
    int kind;   // 0 general, 1 full-scale, 2 off-origin impulse
    int xr[6];
    int xi[6];
  } set_t;

  set_t pend[$];
  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;
  bit have_prev = 1'b0;
  int prev_re[6];
  int prev_im[6];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      nfail++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      finish_run();
    end
  end

  task automatic check_int(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_tol(input string req, input string what, input int act, input real exp);
    real diff;
    nchk++;
    diff = real'(act) - exp;
    if (diff > real'(TOL) || diff < -real'(TOL)) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic verify(input set_t s, input int ar[6], input int ai[6]);
    int dcr, dci, altr, alti;
    bit is_real, is_imp0;
    string xreq;
    dcr = 0; dci = 0; altr = 0; alti = 0;
    is_real = 1'b1; is_imp0 = 1'b1;
    for (int n = 0; n < 6; n++) begin
      dcr += s.xr[n]; dci += s.xi[n];
      altr += (n % 2 == 0) ? s.xr[n] : -s.xr[n];
      alti += (n % 2 == 0) ? s.xi[n] : -s.xi[n];
      if (s.xi[n] != 0) is_real = 1'b0;
      if (n != 0 && (s.xr[n] != 0 || s.xi[n] != 0)) is_imp0 = 1'b0;
    end
    xreq = (s.kind == 1) ? "R8" : "R1";
    check_int(xreq, "bin0 re", ar[0], dcr);
    check_int(xreq, "bin0 im", ai[0], dci);
    xreq = (s.kind == 1) ? "R8" : "R2";
    check_int(xreq, "bin3 re", ar[3], altr);
    check_int(xreq, "bin3 im", ai[3], alti);
    xreq = (s.kind == 2) ? "R4" : "R3";
    for (int k = 1; k < 6; k++) begin
      real er, ei, th;
      if (k == 3) continue;
      er = 0.0; ei = 0.0;
      for (int n = 0; n < 6; n++) begin
        th = 2.0 * PI * real'(n * k) / 6.0;
        er += real'(s.xr[n]) * $cos(th) + real'(s.xi[n]) * $sin(th);
        ei += real'(s.xi[n]) * $cos(th) - real'(s.xr[n]) * $sin(th);
      end
      check_tol(xreq, $sformatf("bin%0d re", k), ar[k], er);
      check_tol(xreq, $sformatf("bin%0d im", k), ai[k], ei);
    end
    if (is_real) begin
      check_int("R7", "re1 vs re5", ar[1], ar[5]);
      check_int("R7", "im1 vs -im5", ai[1], -ai[5]);
      check_int("R7", "re2 vs re4", ar[2], ar[4]);
      check_int("R7", "im2 vs -im4", ai[2], -ai[4]);
    end
    if (is_imp0) begin
      for (int k = 0; k < 6; k++) begin
        check_int("R10", $sformatf("flat bin%0d re", k), ar[k], s.xr[0]);
        check_int("R10", $sformatf("flat bin%0d im", k), ai[k], s.xi[0]);
      end
    end
  endtask

  always @(negedge clk) begin
    int ar[6];
    int ai[6];
    set_t s;
    if (mon_on && !finished) begin
      for (int k = 0; k < 6; k++) begin
        ar[k] = int'($signed(out_re[k]));
        ai[k] = int'($signed(out_im[k]));
      end
      if (pend.size() > 0 && pend[0].due == cyc) begin
        s = pend.pop_front();
        check_int("R5", "valid_out on due cycle", int'(valid_out), 1);
        verify(s, ar, ai);
      end else begin
        check_int("R5", "valid_out idle", int'(valid_out), 0);
        if (have_prev) begin
          for (int k = 0; k < 6; k++) begin
            check_int("R6", $sformatf("hold re%0d", k), ar[k], prev_re[k]);
            check_int("R6", $sformatf("hold im%0d", k), ai[k], prev_im[k]);
          end
        end
      end
      prev_re = ar;
      prev_im = ai;
      have_prev = 1'b1;
    end
  end

  task automatic drive(input bit v, input int xr[6], input int xi[6], input int kind);
    set_t s;
    @(negedge clk);
    valid_in = v;
    for (int n = 0; n < 6; n++) begin
      in_re[n] = DW'(xr[n]);
      in_im[n] = DW'(xi[n]);
    end
    if (v) begin
      s.due = cyc + LAT;
      s.kind = kind;
      s.xr = xr;
      s.xi = xi;
      pend.push_back(s);
    end
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(4095, 0)) - 2048;
  endfunction

  int zr[6] = '{0, 0, 0, 0, 0, 0};

  initial begin
    int xr[6];
    int xi[6];
    rst_n = 1'b0;
    valid_in = 1'b0;
    in_re = '0;
    in_im = '0;
    repeat (4) begin
      @(negedge clk);
      check_int("R9", "valid_out in reset", int'(valid_out), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (4) drive(1'b0, zr, zr, 0);

    // R10 impulse at origin
    xr = zr; xi = zr; xr[0] = 100; xi[0] = -37;
    drive(1'b1, xr, xi, 0);
    repeat (4) drive(1'b0, zr, zr, 0);

    // R4 impulses off the origin
    for (int m = 1; m < 6; m++) begin
      xr = zr; xi = zr; xr[m] = 700 - 200 * m; xi[m] = 50 * m;
      drive(1'b1, xr, xi, 2);
    end

    // R8 full-scale patterns
    for (int n = 0; n < 6; n++) begin xr[n] = PMAX; xi[n] = PMAX; end
    drive(1'b1, xr, xi, 1);
    for (int n = 0; n < 6; n++) begin xr[n] = PMIN; xi[n] = PMIN; end
    drive(1'b1, xr, xi, 1);
    for (int n = 0; n < 6; n++) begin
      xr[n] = (n % 2 == 0) ? PMAX : PMIN;
      xi[n] = (n % 2 == 0) ? PMIN : PMAX;
    end
    drive(1'b1, xr, xi, 1);
    for (int n = 0; n < 6; n++) begin
      xr[n] = (n % 3 == 0) ? PMAX : PMIN;
      xi[n] = 0;
    end
    drive(1'b1, xr, xi, 1);

    // R5 back-to-back complex stream
    for (int i = 0; i < 40; i++) begin
      for (int n = 0; n < 6; n++) begin xr[n] = rnd_s(); xi[n] = rnd_s(); end
      drive(1'b1, xr, xi, 0);
    end

    // R5/R6 gapped stream
    for (int i = 0; i < 60; i++) begin
      for (int n = 0; n < 6; n++) begin xr[n] = rnd_s(); xi[n] = rnd_s(); end
      drive(($urandom_range(1, 0) == 1), xr, xi, 0);
    end

    // R7 real-only stream
    for (int i = 0; i < 30; i++) begin
      for (int n = 0; n < 6; n++) xr[n] = rnd_s();
      drive(1'b1, xr, zr, 0);
    end

    repeat (LAT + 3) drive(1'b0, zr, zr, 0);
    check_int("R5", "sets still pending", pend.size(), 0);
    finish_run();
  end
endmodule